// File: doc/BRIEF.md
# Base-Mask I/O Address Router

This block steers I/O transactions to one of eight destination ports. It holds a small bank of programmable descriptors. Each descriptor names a destination port, says whether it answers normal or special cycles, and gives a 20-bit base with a 20-bit mask. The mask applies to the upper 20 bits of a 32-bit I/O address. Every request carries an address and a special-cycle flag. The block tests the request against all descriptors in parallel, picks the lowest-numbered one that hits, and one cycle later returns that descriptor's port together with a hit indication. A request that hits nothing is reported as a miss and is steered to a fixed default port.

Software programs the descriptors through a register bus. The bus selects a descriptor by a 32-bit register index, and the descriptors sit at consecutive indices from a configurable base index. Each descriptor is one 64-bit word. An access whose index falls outside the descriptor window reads as zero, changes nothing, and pulses an error strobe.

Top module: `iortr_router`

## Requirements
- R1: After reset every descriptor reads back as 0x000000FF_FFF00000, which is a base of all ones, a mask of zero, flag-compare 0 and port 0. After reset `rt_valid` and `reg_err` are low.
- R2: A write stores bits 63:61 (port), bit 60 (flag-compare), bits 39:20 (base) and bits 19:0 (mask). Bits 59:40 always read back as zero, whatever was written to them.
- R3: A descriptor hits only when two conditions hold. First, the address bits 31:12 ANDed with its mask must equal its base. Second, its flag-compare bit must equal the request's special-cycle flag.
- R4: On a hit, `rt_hit` is 1 and `rt_port` equals bits 63:61 of the hitting descriptor.
- R5: When several descriptors hit, the one with the lowest index decides the port.
- R6: When no descriptor hits, `rt_hit` is 0 and `rt_port` equals the parameter DEF_PORT (default 7). A descriptor still at its reset value never hits.
- R7: `rt_valid` is high in exactly the cycles that follow a cycle with `req_valid` high.
- R8: Descriptor k is reached at register index BASE_IDX+k (default BASE_IDX is 0xE0). Read data appears on `reg_rdata` in the cycle after the access and holds until the next read.
- R9: An access to an index below BASE_IDX, or at or above BASE_IDX+N_DESC, loads zero into `reg_rdata` if it is a read. It pulses `reg_err` high for the following cycle only, and it leaves every descriptor unchanged.
- R10: A register write takes effect at the next clock edge. A request presented in the same cycle as a write is routed with the descriptor contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 32 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_err | output | 1 | One-cycle strobe for an out-of-window access |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request I/O address |
| req_special | input | 1 | Special-cycle flag of the request |
| rt_valid | output | 1 | Route result valid |
| rt_hit | output | 1 | 1 = a descriptor hit, 0 = miss |
| rt_port | output | 3 | Destination port |

## Verification
A descriptor write and a routing request can land in the same clock cycle. In that case the write must not leak into the route already being decided. The bench provokes this by rewriting the descriptor that currently catches an address, and presenting a request for that address in the very cycle of the write. It then judges the route against the old contents. It also sends a second request one cycle later and judges that route against the new contents, so the exact edge at which the write takes hold is pinned down.

// File: rtl/iortr_pkg.sv
package iortr_pkg;

    localparam int ADDR_W   = 32;
    localparam int FIELD_W  = 20;
    localparam int PORT_W   = 3;
    localparam int WORD_W   = 64;
    localparam int FIELD_LO = ADDR_W - FIELD_W;

    // bit positions inside a descriptor word (software visible)
    localparam int PORT_HI  = 63;
    localparam int PORT_LO  = 61;
    localparam int FLAG_BIT = 60;
    localparam int BASE_HI  = 39;
    localparam int BASE_LO  = 20;
    localparam int MASK_HI  = 19;
    localparam int MASK_LO  = 0;

    typedef logic [PORT_W-1:0]  port_t;
    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef struct packed {
        port_t  dest;
        logic   flag_cmp;
        field_t base;
        field_t mask;
    } desc_t;

    typedef struct packed {
        logic  valid;
        logic  hit;
        port_t port;
    } route_t;

    localparam desc_t DESC_RST = '{dest: 3'd0, flag_cmp: 1'b0,
                                   base: 20'hFFFFF, mask: 20'h00000};

    function automatic word_t desc_to_word(desc_t d);
        word_t w;
        w = '0;
        w[PORT_HI:PORT_LO] = d.dest;
        w[FLAG_BIT]        = d.flag_cmp;
        w[BASE_HI:BASE_LO] = d.base;
        w[MASK_HI:MASK_LO] = d.mask;
        return w;
    endfunction

    function automatic desc_t word_to_desc(word_t w);
        desc_t d;
        d.dest     = w[PORT_HI:PORT_LO];
        d.flag_cmp = w[FLAG_BIT];
        d.base     = w[BASE_HI:BASE_LO];
        d.mask     = w[MASK_HI:MASK_LO];
        return d;
    endfunction

    function automatic logic desc_hits(desc_t d, field_t f, logic special);
        return ((f & d.mask) == d.base) && (d.flag_cmp == special);
    endfunction

endpackage

// File: rtl/iortr_regs.sv
module iortr_regs
    import iortr_pkg::*;
#(
    parameter int          N_DESC   = 4,
    parameter logic [31:0] BASE_IDX = 32'h0000_00E0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 we,
    input  logic [31:0]          idx,
    input  word_t                wdata,
    output word_t                rdata,
    output logic                 err,
    output desc_t [N_DESC-1:0]   descs
);

    localparam logic [31:0] N_DESC_L = 32'(N_DESC);

    logic [31:0] off;
    logic        in_win;
    word_t       rd_word;

    assign off    = idx - BASE_IDX;
    assign in_win = (idx >= BASE_IDX) && (off < N_DESC_L);

    for (genvar k = 0; k < N_DESC; k++) begin : g_desc
        always_ff @(posedge clk) begin
            if (rst) begin
                descs[k] <= DESC_RST;
            end else if (sel && we && in_win && (off == 32'(k))) begin
                descs[k] <= word_to_desc(wdata);
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_DESC; k++) begin
            if (in_win && (off == 32'(k))) begin
                rd_word = desc_to_word(descs[k]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= sel && !in_win;
            if (sel && !we) begin
                rdata <= in_win ? rd_word : '0;
            end
        end
    end

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(sel && !in_win));

    // R9
    oor_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sel && we && !in_win) |-> (descs == $past(descs)));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata[59:40] == 20'h0);

endmodule

// File: rtl/iortr_match.sv
module iortr_match
    import iortr_pkg::*;
#(
    parameter int N_DESC = 4
) (
    input  desc_t [N_DESC-1:0] descs,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               special,
    output logic [N_DESC-1:0]  hits
);

    field_t field;
    assign field = addr[ADDR_W-1:FIELD_LO];

    for (genvar k = 0; k < N_DESC; k++) begin : g_cmp
        assign hits[k] = desc_hits(descs[k], field, special);
    end

endmodule

// File: rtl/iortr_pick.sv
module iortr_pick
    import iortr_pkg::*;
#(
    parameter int    N_DESC   = 4,
    parameter port_t DEF_PORT = 3'd7
) (
    input  desc_t [N_DESC-1:0] descs,
    input  logic [N_DESC-1:0]  hits,
    output logic [N_DESC-1:0]  grant,
    output logic               any_hit,
    output port_t              port
);

    always_comb begin
        grant   = '0;
        any_hit = 1'b0;
        port    = DEF_PORT;
        for (int k = N_DESC - 1; k >= 0; k--) begin
            if (hits[k]) begin
                grant    = '0;
                grant[k] = 1'b1;
                any_hit  = 1'b1;
                port     = descs[k].dest;
            end
        end
    end

endmodule

// File: rtl/iortr_router.sv
module iortr_router
    import iortr_pkg::*;
#(
    parameter int          N_DESC   = 4,
    parameter logic [31:0] BASE_IDX = 32'h0000_00E0,
    parameter logic [2:0]  DEF_PORT = 3'd7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_idx,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        reg_err,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_special,
    output logic        rt_valid,
    output logic        rt_hit,
    output logic [2:0]  rt_port
);

    desc_t [N_DESC-1:0] descs;
    logic  [N_DESC-1:0] hits;
    logic  [N_DESC-1:0] grant;
    logic               any_hit;
    port_t              pick_port;
    route_t             route_q;

    iortr_regs #(.N_DESC(N_DESC), .BASE_IDX(BASE_IDX)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (reg_sel),
        .we    (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .err   (reg_err),
        .descs (descs)
    );

    iortr_match #(.N_DESC(N_DESC)) u_match (
        .descs   (descs),
        .addr    (req_addr),
        .special (req_special),
        .hits    (hits)
    );

    iortr_pick #(.N_DESC(N_DESC), .DEF_PORT(DEF_PORT)) u_pick (
        .descs   (descs),
        .hits    (hits),
        .grant   (grant),
        .any_hit (any_hit),
        .port    (pick_port)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else begin
            route_q.valid <= req_valid;
            if (req_valid) begin
                route_q.hit  <= any_hit;
                route_q.port <= pick_port;
            end
        end
    end

    assign rt_valid = route_q.valid;
    assign rt_hit   = route_q.hit;
    assign rt_port  = route_q.port;

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((hits & (grant - 1'b1)) == '0));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rt_valid == $past(req_valid));

    // R6
    miss_default_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && !rt_hit) |-> (rt_port == DEF_PORT));

    // R4
    hit_has_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (hits != '0)) |=> (rt_valid && rt_hit));

endmodule

// File: tb/test_iortr_router.sv
module test_iortr_router;

    localparam logic [31:0] BI = 32'h0000_00E0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_special = 1'b0;
    logic        rt_valid;
    logic        rt_hit;
    logic [2:0]  rt_port;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    iortr_router i_iortr_router (
        .clk(clk), .rst(rst),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .req_valid(req_valid), .req_addr(req_addr), .req_special(req_special),
        .rt_valid(rt_valid), .rt_hit(rt_hit), .rt_port(rt_port)
    );

    function automatic logic [63:0] mk(logic [2:0] p, logic f,
                                       logic [19:0] b, logic [19:0] m);
        return {p, f, 20'h0, b, m};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [31:0] idx, logic [63:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [31:0] idx, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_idx = idx;
        @(posedge clk); #1;
        d = reg_rdata; e = reg_err;
        reg_sel = 1'b0;
    endtask

    task automatic route(logic [31:0] a, logic sp,
                         output logic v, output logic h, output logic [2:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_special = sp;
        @(posedge clk); #1;
        v = rt_valid; h = rt_hit; p = rt_port;
        req_valid = 1'b0;
    endtask

    task automatic expect_route(string req, logic [31:0] a, logic sp,
                                logic eh, logic [2:0] ep);
        logic v, h;
        logic [2:0] p;
        route(a, sp, v, h, p);
        chk(req, "rt_valid", 64'(v), 64'(1'b1));
        chk(req, "rt_hit", 64'(h), 64'(eh));
        chk(req, "rt_port", 64'(p), 64'(ep));
    endtask

    task automatic t_reset;
        logic [63:0] d;
        logic e;
        chk("R1", "rt_valid after reset", 64'(rt_valid), 64'(1'b0));
        chk("R1", "reg_err after reset", 64'(reg_err), 64'(1'b0));
        for (int k = 0; k < 4; k++) begin
            reg_rd(BI + 32'(k), d, e);
            chk("R1", "reset descriptor", d, 64'h0000_00FF_FFF0_0000);
            chk("R8", "no error in window", 64'(e), 64'(1'b0));
        end
        expect_route("R6", 32'h0000_0000, 1'b0, 1'b0, 3'd7);
        expect_route("R6", 32'hFFFF_F000, 1'b1, 1'b0, 3'd7);
    endtask

    task automatic t_rw;
        logic [63:0] d;
        logic e;
        reg_wr(BI + 1, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(BI + 1, d, e);
        chk("R2", "reserved bits read zero", d, 64'hF000_00FF_FFFF_FFFF);
        reg_wr(BI + 2, mk(3'd3, 1'b0, 20'hABCDE, 20'h12345));
        reg_rd(BI + 2, d, e);
        chk("R8", "index maps to descriptor 2", d, mk(3'd3, 1'b0, 20'hABCDE, 20'h12345));
        reg_rd(BI + 1, d, e);
        chk("R8", "descriptor 1 untouched", d, 64'hF000_00FF_FFFF_FFFF);
        @(posedge clk); #1;
        chk("R8", "read data holds", reg_rdata, 64'hF000_00FF_FFFF_FFFF);
    endtask

    task automatic t_match;
        reg_wr(BI + 0, mk(3'd5, 1'b0, 20'h00001, 20'hFFFFF));
        reg_wr(BI + 1, mk(3'd2, 1'b1, 20'h00001, 20'hFFFFF));
        reg_wr(BI + 2, mk(3'd6, 1'b0, 20'h00500, 20'hFFF00));
        reg_wr(BI + 3, 64'h0000_00FF_FFF0_0000);
        expect_route("R3", 32'h0000_1234, 1'b0, 1'b1, 3'd5);
        expect_route("R3", 32'h0000_1234, 1'b1, 1'b1, 3'd2);
        expect_route("R4", 32'h005A_B000, 1'b0, 1'b1, 3'd6);
        expect_route("R3", 32'h005A_B000, 1'b1, 1'b0, 3'd7);
        expect_route("R3", 32'h0000_2000, 1'b0, 1'b0, 3'd7);
    endtask

    task automatic t_prio;
        reg_wr(BI + 3, mk(3'd4, 1'b0, 20'h00000, 20'h00000));
        expect_route("R5", 32'h0000_1000, 1'b0, 1'b1, 3'd5);
        expect_route("R5", 32'h0050_0000, 1'b0, 1'b1, 3'd6);
        expect_route("R4", 32'h7777_7000, 1'b0, 1'b1, 3'd4);
        expect_route("R6", 32'h7777_7000, 1'b1, 1'b0, 3'd7);
    endtask

    task automatic t_valid;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h0000_1000;
        @(posedge clk); #1;
        chk("R7", "no request no valid", 64'(rt_valid), 64'(1'b0));
        @(posedge clk); #1;
        chk("R7", "still idle", 64'(rt_valid), 64'(1'b0));
    endtask

    task automatic t_oor;
        logic [63:0] d;
        logic e;
        reg_rd(BI + 1, d, e);
        reg_rd(BI + 4, d, e);
        chk("R9", "read above window data", d, 64'h0);
        chk("R9", "read above window err", 64'(e), 64'(1'b1));
        @(posedge clk); #1;
        chk("R9", "err single cycle", 64'(reg_err), 64'(1'b0));
        reg_rd(BI - 1, d, e);
        chk("R9", "read below window err", 64'(e), 64'(1'b1));
        reg_wr(BI + 4, 64'h2000_0000_0000_0000);
        chk("R9", "write out of window err", 64'(reg_err), 64'(1'b1));
        reg_rd(BI + 0, d, e);
        chk("R9", "descriptor 0 unchanged", d, mk(3'd5, 1'b0, 20'h00001, 20'hFFFFF));
        reg_rd(BI + 3, d, e);
        chk("R9", "descriptor 3 unchanged", d, mk(3'd4, 1'b0, 20'h00000, 20'h00000));
    endtask

    task automatic t_same_cycle;
        logic [63:0] d;
        logic e;
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_idx = BI + 3;
        reg_wdata = mk(3'd1, 1'b1, 20'h77777, 20'hFFFFF);
        req_valid = 1'b1; req_addr = 32'h7777_7000; req_special = 1'b0;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_we = 1'b0;
        req_valid = 1'b1; req_addr = 32'h7777_7000; req_special = 1'b0;
        chk("R10", "old contents route valid", 64'(rt_valid), 64'(1'b1));
        chk("R10", "old contents route hit", 64'(rt_hit), 64'(1'b1));
        chk("R10", "old contents route port", 64'(rt_port), 64'(3'd4));
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R10", "new contents miss", 64'(rt_hit), 64'(1'b0));
        chk("R10", "new contents default", 64'(rt_port), 64'(3'd7));
        expect_route("R10", 32'h7777_7000, 1'b1, 1'b1, 3'd1);
        reg_rd(BI + 3, d, e);
        chk("R10", "write landed", d, mk(3'd1, 1'b1, 20'h77777, 20'hFFFFF));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset;
        t_rw;
        t_match;
        t_prio;
        t_valid;
        t_oor;
        t_same_cycle;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule